// File: doc/BRIEF.md
# LIN Response Timeout Monitor

This block supervises a LIN frame in which the master sends the header and a slave has to supply the response. Timing starts on the falling edge of the break that the master transmits. From then on the block counts transmit bit periods, using a one-cycle bit tick supplied by the surrounding bit-rate logic. If a frame-complete strobe does not arrive before the count reaches the frame's limit, the block raises a sticky slave-not-responding flag.

The limit comes from one of two sources. It can be a programmed bit count, or a compliant default built from the frame's data-byte count. That default is 1.4 times (10 per byte plus 45) bit times, rounded up. The block latches the limit at the break edge, so the frame in progress keeps its limit if the source changes later. Frames that need no slave answer are marked at the break edge and are not timed. The flag stays set until software clears it with a one-cycle clear pulse.

Top module: `lin_resp_timeout`

## Requirements
- R1: A break edge (`brk_fall`=1) with `rx_frame`=1 starts timing from a count of zero, and `busy` reads 1 from the next cycle.
- R2: A break edge with `rx_frame`=0 starts no timing. `busy` stays 0 and no number of ticks sets `sto_flag`.
- R3: Only cycles with `bit_tick`=1 advance the count. If no frame-complete strobe has come, the tick that makes the count since the break equal to the latched limit sets `sto_flag` in the next cycle and clears `busy`.
- R4: A `frame_done` pulse that arrives before the terminal tick, or in the same cycle as it, ends timing. `busy` goes to 0 and `sto_flag` is not set.
- R5: `sto_flag` holds its value until a `sto_clr` pulse clears it. If a timeout and a clear occur in the same cycle, the flag reads 1.
- R6: A break edge with `rx_frame`=1 that arrives while a frame is being timed restarts the count from zero. A break edge never clears `sto_flag`.
- R7: With `use_default`=1 the limit is ceil(14*(10*n+45)/10) bit times, where n is `ndata` clamped into 1..8 (0 counts as 1, and values above 8 count as 8). This gives 77 for n=1 and 175 for n=8.
- R8: The limit is sampled at the starting break edge. Changes to `to_value`, `use_default` or `ndata` after that edge do not affect the current frame.
- R9: A latched limit of 0 expires on the first tick after the break.
- R10: After reset, `sto_flag` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle pulse per transmit bit period |
| brk_fall | input | 1 | One-cycle pulse on the falling edge of the transmitted break |
| rx_frame | input | 1 | Qualifies `brk_fall`: 1 when a slave must answer |
| frame_done | input | 1 | One-cycle strobe when the whole frame has been received |
| use_default | input | 1 | 1 selects the limit computed from `ndata`, 0 selects `to_value` |
| to_value | input | CNT_W | Programmed limit in bit times |
| ndata | input | NDATA_W | Number of data bytes in the frame |
| sto_clr | input | 1 | Write-one-to-clear pulse for `sto_flag` |
| sto_flag | output | 1 | Sticky slave-not-responding flag |
| busy | output | 1 | A frame is being timed |

## Verification
The hardest cases to reach are those where events share a cycle. The first is a frame-complete strobe that lands on the very tick that would expire the frame. The second is a clear pulse that coincides with a fresh expiry. From the ports, these cases can only be set up by counting ticks exactly from the break edge. The bench therefore issues ticks one at a time and raises `frame_done` or `sto_clr` in the same cycle as the limit-th tick. It also runs the compliant default limits out to their full length, one tick short of the limit and then on it, for clamped and unclamped byte counts.

// File: rtl/lin_to_pkg.sv
package lin_to_pkg;
  localparam int unsigned MIN_BYTES = 1;
  localparam int unsigned MAX_BYTES = 8;

  typedef enum logic {ST_IDLE = 1'b0, ST_TIMING = 1'b1} tmr_state_e;

  // Byte count forced into the legal range of a LIN data field.
  function automatic int unsigned clamp_bytes(input int unsigned n);
    if (n < MIN_BYTES) return MIN_BYTES;
    if (n > MAX_BYTES) return MAX_BYTES;
    return n;
  endfunction

  // Longest permitted frame in bit times, rounded up: 1.4 * (10*n + 45).
  function automatic int unsigned frame_max_bits(input int unsigned n);
    int unsigned b;
    b = clamp_bytes(n);
    return (14 * (10 * b + 45) + 9) / 10;
  endfunction
endpackage

// File: rtl/lin_to_limit.sv
module lin_to_limit #(
  parameter int CNT_W   = 10,
  parameter int NDATA_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               use_default,
  input  logic [CNT_W-1:0]   to_value,
  input  logic [NDATA_W-1:0] ndata,
  output logic [CNT_W-1:0]   limit_q
);
  import lin_to_pkg::*;

  logic [CNT_W-1:0] dflt_lim;
  logic [CNT_W-1:0] sel_lim;

  always_comb begin
    dflt_lim = CNT_W'(frame_max_bits(int'(unsigned'(ndata))));
    sel_lim  = use_default ? dflt_lim : to_value;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    limit_q <= '0;
    else if (load) limit_q <= sel_lim;
  end
endmodule

// File: rtl/lin_to_counter.sv
module lin_to_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic             tick,
  input  logic             done,
  input  logic [CNT_W-1:0] limit,
  output logic             busy,
  output logic             expire
);
  import lin_to_pkg::*;

  tmr_state_e       state_q;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W:0]   cnt_nxt;

  assign busy = (state_q == ST_TIMING);

  always_comb begin
    cnt_nxt = {1'b0, count_q} + {{CNT_W{1'b0}}, 1'b1};
    expire  = busy && tick && !done && (cnt_nxt >= {1'b0, limit});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      count_q <= '0;
    end else if (start) begin
      state_q <= ST_TIMING;
      count_q <= '0;
    end else if (abort) begin
      state_q <= ST_IDLE;
    end else if (busy) begin
      if (done || expire) state_q <= ST_IDLE;
      else if (tick)      count_q <= cnt_nxt[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/lin_to_flag.sv
module lin_to_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/lin_resp_timeout.sv
module lin_resp_timeout #(
  parameter int CNT_W   = 10,
  parameter int NDATA_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_tick,
  input  logic               brk_fall,
  input  logic               rx_frame,
  input  logic               frame_done,
  input  logic               use_default,
  input  logic [CNT_W-1:0]   to_value,
  input  logic [NDATA_W-1:0] ndata,
  input  logic               sto_clr,
  output logic               sto_flag,
  output logic               busy
);
  logic             start_ev;
  logic             abort_ev;
  logic             expire_ev;
  logic [CNT_W-1:0] limit_q;

  assign start_ev = brk_fall & rx_frame;
  assign abort_ev = brk_fall & ~rx_frame;

  lin_to_limit #(.CNT_W(CNT_W), .NDATA_W(NDATA_W)) limit_i (
    .clk(clk), .rst_n(rst_n), .load(start_ev), .use_default(use_default),
    .to_value(to_value), .ndata(ndata), .limit_q(limit_q)
  );

  lin_to_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .start(start_ev), .abort(abort_ev),
    .tick(bit_tick), .done(frame_done), .limit(limit_q),
    .busy(busy), .expire(expire_ev)
  );

  lin_to_flag flag_i (
    .clk(clk), .rst_n(rst_n), .set(expire_ev), .clr(sto_clr), .flag(sto_flag)
  );
endmodule

// File: rtl/lin_resp_timeout_chk.sv
module lin_resp_timeout_chk (
  input logic clk,
  input logic rst_n,
  input logic brk_fall,
  input logic rx_frame,
  input logic frame_done,
  input logic sto_clr,
  input logic start_ev,
  input logic expire_ev,
  input logic sto_flag,
  input logic busy
);
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_fall && rx_frame) |=> busy); // R1
  AST_UNQUALIFIED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_fall && !rx_frame) |=> !busy); // R2
  AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    expire_ev |=> sto_flag); // R3
  AST_EXPIRE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    expire_ev |-> busy); // R3
  AST_DONE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && frame_done && !start_ev) |=> !busy); // R4
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!sto_flag && !expire_ev) |=> !sto_flag); // R4
  AST_STO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sto_flag && !sto_clr) |=> sto_flag); // R5
  AST_STO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sto_clr && !expire_ev) |=> !sto_flag); // R5
endmodule

bind lin_resp_timeout lin_resp_timeout_chk chk_i (
  .clk(clk), .rst_n(rst_n), .brk_fall(brk_fall), .rx_frame(rx_frame),
  .frame_done(frame_done), .sto_clr(sto_clr), .start_ev(start_ev),
  .expire_ev(expire_ev), .sto_flag(sto_flag), .busy(busy)
);

// File: tb/lin_resp_timeout_tb.sv
`timescale 1ns/1ps
module lin_resp_timeout_tb_top;
  localparam int CNT_W   = 10;
  localparam int NDATA_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0, brk_fall = 1'b0, rx_frame = 1'b1, frame_done = 1'b0;
  logic use_default = 1'b0, sto_clr = 1'b0;
  logic [CNT_W-1:0] to_value = '0;
  logic [NDATA_W-1:0] ndata = '0;
  logic sto_flag, busy;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  lin_resp_timeout #(.CNT_W(CNT_W), .NDATA_W(NDATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .brk_fall(brk_fall),
    .rx_frame(rx_frame), .frame_done(frame_done), .use_default(use_default),
    .to_value(to_value), .ndata(ndata), .sto_clr(sto_clr),
    .sto_flag(sto_flag), .busy(busy)
  );

  // Compliant limit restated: 1.4*(10n+45) = 14n + 63 with n clamped to 1..8.
  function automatic int exp_default(input int n);
    int c;
    c = (n < 1) ? 1 : ((n > 8) ? 8 : n);
    return 14 * c + 63;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Each helper drives for one clock edge and returns at the following
  // falling edge, where the registered outputs are sampled.
  task automatic pulse(input logic t, input logic b, input logic d, input logic c);
    @(negedge clk);
    bit_tick = t; brk_fall = b; frame_done = d; sto_clr = c;
    @(negedge clk);
    bit_tick = 1'b0; brk_fall = 1'b0; frame_done = 1'b0; sto_clr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) pulse(1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic clear_flag();
    pulse(1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_reset();
    chk("R10 flag after reset", sto_flag, 1'b0);
    chk("R10 busy after reset", busy, 1'b0);
  endtask

  task automatic t_basic_expiry();
    use_default = 1'b0; to_value = 10'd5; rx_frame = 1'b1;
    pulse(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R1 busy after break", busy, 1'b1);
    ticks(4);
    chk("R3 no flag one tick short", sto_flag, 1'b0);
    chk("R3 still busy one tick short", busy, 1'b1);
    ticks(1);
    chk("R3 flag at limit", sto_flag, 1'b1);
    chk("R3 busy drops at expiry", busy, 1'b0);
    ticks(3);
    chk("R5 flag sticky without clear", sto_flag, 1'b1);
    clear_flag();
    chk("R5 clear pulse clears flag", sto_flag, 1'b0);
  endtask

  task automatic t_done_early();
    to_value = 10'd5;
    pulse(1'b0, 1'b1, 1'b0, 1'b0);
    ticks(3);
    pulse(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R4 done ends timing", busy, 1'b0);
    ticks(10);
    chk("R4 no flag after early done", sto_flag, 1'b0);
  endtask

  task automatic t_done_on_terminal();
    to_value = 10'd5;
    pulse(1'b0, 1'b1, 1'b0, 1'b0);
    ticks(4);
    pulse(1'b1, 1'b0, 1'b1, 1'b0);
    chk("R4 done on terminal tick no flag", sto_flag, 1'b0);
    chk("R4 done on terminal tick idle", busy, 1'b0);
  endtask

  task automatic t_restart();
    to_value = 10'd6;
    pulse(1'b0, 1'b1, 1'b0, 1'b0);
    ticks(4);
    pulse(1'b0, 1'b1, 1'b0, 1'b0);
    ticks(5);
    chk("R6 restart: no flag after 5 new ticks", sto_flag, 1'b0);
    chk("R6 restart: still busy", busy, 1'b1);
    ticks(1);
    chk("R6 restart: flag at full limit", sto_flag, 1'b1);
    pulse(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R6 break keeps flag", sto_flag, 1'b1);
    pulse(1'b0, 1'b0, 1'b1, 1'b0);
    clear_flag();
  endtask

  task automatic t_default(input int n);
    int lim;
    lim = exp_default(n);
    use_default = 1'b1; ndata = NDATA_W'(n); to_value = 10'd3;
    pulse(1'b0, 1'b1, 1'b0, 1'b0);
    ticks(lim - 1);
    chk($sformatf("R7 ndata=%0d no flag at %0d", n, lim - 1), sto_flag, 1'b0);
    ticks(1);
    chk($sformatf("R7 ndata=%0d flag at %0d", n, lim), sto_flag, 1'b1);
    clear_flag();
    use_default = 1'b0;
  endtask

  task automatic t_latched_limit();
    to_value = 10'd4;
    pulse(1'b0, 1'b1, 1'b0, 1'b0);
    to_value = 10'd50; use_default = 1'b1; ndata = 4'd8;
    ticks(4);
    chk("R8 limit latched at break", sto_flag, 1'b1);
    use_default = 1'b0;
    clear_flag();
  endtask

  task automatic t_zero_limit();
    to_value = 10'd0;
    pulse(1'b0, 1'b1, 1'b0, 1'b0);
    ticks(1);
    chk("R9 zero limit expires on first tick", sto_flag, 1'b1);
    clear_flag();
  endtask

  task automatic t_unqualified();
    to_value = 10'd3; rx_frame = 1'b0;
    pulse(1'b0, 1'b1, 1'b0, 1'b0);
    chk("R2 no busy for non-receive frame", busy, 1'b0);
    ticks(20);
    chk("R2 no flag for non-receive frame", sto_flag, 1'b0);
    rx_frame = 1'b1;
  endtask

  task automatic t_set_beats_clear();
    to_value = 10'd2;
    pulse(1'b0, 1'b1, 1'b0, 1'b0);
    ticks(2);
    pulse(1'b0, 1'b1, 1'b0, 1'b0);
    ticks(1);
    pulse(1'b1, 1'b0, 1'b0, 1'b1);
    chk("R5 set wins over same-cycle clear", sto_flag, 1'b1);
    clear_flag();
    chk("R5 later clear works", sto_flag, 1'b0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_expiry();
    t_done_early();
    t_done_on_terminal();
    t_restart();
    t_default(1);
    t_default(8);
    t_default(0);
    t_default(12);
    t_default(3);
    t_latched_limit();
    t_zero_limit();
    t_unqualified();
    t_set_beats_clear();
    finish_run();
  end
endmodule